// File: doc/BRIEF.md
# Precise Exception Sequencer for a Five-Stage Pipeline

This block keeps order among faults in an in-order pipeline with five stages. It holds a small shadow latch per stage that travels with each instruction. A stage that finds a problem with its instruction drives a nonzero fault code on its own input slice, and that code is stored in the shadow latch. The block acts only when the instruction reaches writeback, the last stage. There it checks the latch on every cycle. A nonzero code at that point loads the fault code register and the saved-PC register. It also flushes every younger stage, redirects fetch to a vector entry chosen by the code, and switches the core into privileged mode. Faults are therefore taken in program order and are precise: every older instruction completes, and neither the faulting instruction nor any younger one does.

A mode state machine has two states. USER is entered at reset. PRIV is entered on the USER->PRIV transition (TAKE) and is re-entered on PRIV->PRIV (NESTED TAKE). From PRIV, the return strobe causes the PRIV->USER transition (RETURN), which restarts fetch at the saved PC or at the saved PC plus 4. In USER the return strobe keeps the machine in USER (IGNORED RETURN). The surrounding core uses `wb_commit` as the write enable for register results, `squash_younger` to turn the younger stages into no-ops, and `redirect_valid` with `redirect_pc` to steer fetch.

Top module: `precise_exc_ctrl`

## Requirements
- R1: After reset the mode is user (`priv_mode`=0), `cause_reg` and `epc_reg` are 0, and `redirect_valid`, `squash_younger` and `wb_commit` are all 0.
- R2: Fault codes are 3 bits: 0 none, 1 unknown opcode, 2 divide by zero, 3 privileged instruction, 4 privileged address, 5 misaligned load, 6 illegal load address, 7 translation miss. Stage k (0 fetch … 4 writeback) drives bits [3k+2:3k] of `raise_cause`. When one instruction raises codes in several stages, the code from the earliest stage is the one recorded.
- R3: A fault is acted on only in the cycle the faulting instruction is in writeback. An instruction fetched in cycle c is in writeback in cycle c+5, and `redirect_valid` stays 0 before that cycle.
- R4: In the cycle after a fault is taken, `cause_reg` holds the recorded code and `epc_reg` holds the PC of the faulting instruction.
- R5: In the cycle a fault is taken, `redirect_pc` equals VEC_BASE + 16 × code.
- R6: Faults are taken in program order. An older instruction's fault is taken even when a younger instruction raised its fault earlier in time.
- R7: Every instruction older than the faulting one asserts `wb_commit` in writeback. The faulting instruction does not.
- R8: In the cycle a fault is taken, every bit of `squash_younger` is 1. No squashed instruction later asserts `wb_commit`.
- R9: Taking a fault sets `priv_mode` to 1 in the following cycle, whether the mode was user or privileged.
- R10: In privileged mode, `eret_req` redirects fetch in the same cycle to `epc_reg` (`eret_skip`=0) or to `epc_reg`+4 (`eret_skip`=1), flushes the younger stages, and clears `priv_mode` in the next cycle.
- R11: In user mode, `eret_req` has no effect: there is no redirect and no squash, and `priv_mode` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | An instruction enters the fetch stage this cycle |
| fetch_pc | input | XLEN | PC of the instruction entering fetch |
| raise_cause | input | NSTG*3 | Per-stage fault code for the instruction held in that stage |
| eret_req | input | 1 | Return-from-handler strobe |
| eret_skip | input | 1 | 1 resumes after the faulting instruction, 0 resumes at it |
| wb_commit | output | 1 | The writeback instruction may write its result |
| squash_younger | output | NSTG-1 | Turn stages fetch through memory into no-ops |
| redirect_valid | output | 1 | Fetch must restart at redirect_pc |
| redirect_pc | output | XLEN | Restart address |
| cause_reg | output | 3 | Recorded fault code |
| epc_reg | output | XLEN | Recorded PC of the faulting instruction |
| priv_mode | output | 1 | 1 while in privileged mode |

## Verification
The properties assume that the core stops presenting a squashed instruction once `squash_younger` has been raised. They also assume that `eret_req` is a single-cycle strobe that is 0 while reset is active. The bench stays within both assumptions. It drives `fetch_valid` low after every redirect and pulses `eret_req` for exactly one cycle. It places each fault code on the stage slice that matches the instruction's age, so every raise belongs to a live instruction.

// File: rtl/pexc_pkg.sv
package pexc_pkg;

    typedef enum logic [2:0] {
        EXC_NONE        = 3'd0,
        EXC_BAD_OPCODE  = 3'd1,
        EXC_DIV_ZERO    = 3'd2,
        EXC_PRIV_INSN   = 3'd3,
        EXC_PRIV_ADDR   = 3'd4,
        EXC_MISALIGN_LD = 3'd5,
        EXC_BAD_LD_ADDR = 3'd6,
        EXC_XLATE_MISS  = 3'd7
    } exc_cause_e;

    typedef enum logic {
        MODE_USER = 1'b0,
        MODE_PRIV = 1'b1
    } core_mode_e;

    localparam int CAUSE_W = $bits(exc_cause_e);

endpackage

// File: rtl/pexc_stage_chain.sv
module pexc_stage_chain
    import pexc_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NSTG = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fetch_valid,
    input  logic [XLEN-1:0]         fetch_pc,
    input  logic [NSTG*CAUSE_W-1:0] raise_cause,
    input  logic                    flush,
    output logic                    wb_valid,
    output logic [XLEN-1:0]         wb_pc,
    output logic [CAUSE_W-1:0]      wb_cause
);

    localparam int LAST = NSTG - 1;

    logic               vld_q   [NSTG];
    logic [XLEN-1:0]    pc_q    [NSTG];
    logic [CAUSE_W-1:0] code_q  [NSTG];
    logic [CAUSE_W-1:0] merged  [NSTG];

    // earliest recorded code wins; a live stage adds its own raise otherwise
    for (genvar i = 0; i < NSTG; i++) begin : g_merge
        assign merged[i] = (code_q[i] != EXC_NONE) ? code_q[i]
                         : (vld_q[i] ? raise_cause[i*CAUSE_W +: CAUSE_W] : EXC_NONE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q[0]  <= 1'b0;
            pc_q[0]   <= '0;
            code_q[0] <= EXC_NONE;
        end else begin
            vld_q[0]  <= fetch_valid & ~flush;
            pc_q[0]   <= fetch_pc;
            code_q[0] <= EXC_NONE;
        end
    end

    for (genvar i = 1; i < NSTG; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[i]  <= 1'b0;
                pc_q[i]   <= '0;
                code_q[i] <= EXC_NONE;
            end else begin
                vld_q[i]  <= vld_q[i-1] & ~flush;
                pc_q[i]   <= pc_q[i-1];
                code_q[i] <= (vld_q[i-1] & ~flush) ? merged[i-1] : EXC_NONE;
            end
        end
    end

    assign wb_valid = vld_q[LAST];
    assign wb_pc    = pc_q[LAST];
    assign wb_cause = merged[LAST];

endmodule

// File: rtl/pexc_mode_fsm.sv
module pexc_mode_fsm
    import pexc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    input  logic [CAUSE_W-1:0] take_cause,
    input  logic [XLEN-1:0]    take_pc,
    input  logic               eret_req,
    output logic               ret_go,
    output logic               priv_mode,
    output logic [CAUSE_W-1:0] cause_reg,
    output logic [XLEN-1:0]    epc_reg
);

    core_mode_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_USER;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        ret_go  = 1'b0;
        unique case (state_q)
            MODE_USER: begin
                if (take) state_d = MODE_PRIV;          // TAKE
            end
            MODE_PRIV: begin
                if (take) begin
                    state_d = MODE_PRIV;                // NESTED TAKE
                end else if (eret_req) begin
                    state_d = MODE_USER;                // RETURN
                    ret_go  = 1'b1;
                end
            end
            default: state_d = MODE_USER;
        endcase
    end

    assign priv_mode = (state_q == MODE_PRIV);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_reg <= EXC_NONE;
            epc_reg   <= '0;
        end else if (take) begin
            cause_reg <= take_cause;
            epc_reg   <= take_pc;
        end
    end

endmodule

// File: rtl/pexc_vector.sv
module pexc_vector
    import pexc_pkg::*;
#(
    parameter int          XLEN        = 32,
    parameter int unsigned VEC_BASE    = 32'h0000_0100,
    parameter int          ENTRY_BYTES = 16
) (
    input  logic               take,
    input  logic [CAUSE_W-1:0] cause,
    input  logic               ret_go,
    input  logic               ret_skip,
    input  logic [XLEN-1:0]    epc,
    output logic               redirect_valid,
    output logic [XLEN-1:0]    redirect_pc
);

    localparam int SHIFT = $clog2(ENTRY_BYTES);
    localparam logic [XLEN-1:0] BASE = XLEN'(VEC_BASE);

    logic [XLEN-1:0] entry_addr;
    logic [XLEN-1:0] resume_addr;

    assign entry_addr  = BASE + ({{(XLEN-CAUSE_W){1'b0}}, cause} << SHIFT);
    assign resume_addr = ret_skip ? (epc + XLEN'(4)) : epc;

    assign redirect_valid = take | ret_go;
    assign redirect_pc    = take ? entry_addr : resume_addr;

endmodule

// File: rtl/precise_exc_ctrl.sv
module precise_exc_ctrl
    import pexc_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter int          NSTG     = 5,
    parameter int unsigned VEC_BASE = 32'h0000_0100
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fetch_valid,
    input  logic [XLEN-1:0]         fetch_pc,
    input  logic [NSTG*CAUSE_W-1:0] raise_cause,
    input  logic                    eret_req,
    input  logic                    eret_skip,
    output logic                    wb_commit,
    output logic [NSTG-2:0]         squash_younger,
    output logic                    redirect_valid,
    output logic [XLEN-1:0]         redirect_pc,
    output logic [CAUSE_W-1:0]      cause_reg,
    output logic [XLEN-1:0]         epc_reg,
    output logic                    priv_mode
);

    logic               wb_valid;
    logic [XLEN-1:0]    wb_pc;
    logic [CAUSE_W-1:0] wb_cause;
    logic               take;
    logic               ret_go;

    pexc_stage_chain #(.XLEN(XLEN), .NSTG(NSTG)) u_chain (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_valid (fetch_valid),
        .fetch_pc    (fetch_pc),
        .raise_cause (raise_cause),
        .flush       (redirect_valid),
        .wb_valid    (wb_valid),
        .wb_pc       (wb_pc),
        .wb_cause    (wb_cause)
    );

    assign take      = wb_valid & (wb_cause != EXC_NONE);
    assign wb_commit = wb_valid & ~take;

    pexc_mode_fsm #(.XLEN(XLEN)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .take_cause (wb_cause),
        .take_pc    (wb_pc),
        .eret_req   (eret_req),
        .ret_go     (ret_go),
        .priv_mode  (priv_mode),
        .cause_reg  (cause_reg),
        .epc_reg    (epc_reg)
    );

    pexc_vector #(.XLEN(XLEN), .VEC_BASE(VEC_BASE), .ENTRY_BYTES(16)) u_vec (
        .take           (take),
        .cause          (wb_cause),
        .ret_go         (ret_go),
        .ret_skip       (eret_skip),
        .epc            (epc_reg),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc)
    );

    assign squash_younger = {(NSTG-1){redirect_valid}};

endmodule

// File: rtl/pexc_checker.sv
module pexc_checker #(
    parameter int NSTG = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            take,
    input logic            eret_req,
    input logic            wb_commit,
    input logic [NSTG-2:0] squash_younger,
    input logic            redirect_valid,
    input logic [2:0]      cause_reg,
    input logic            priv_mode
);

    a_r7_no_commit_on_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> !wb_commit);

    a_r8_squash_all: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (&squash_younger));

    a_r8_clean_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !wb_commit);

    a_r4_cause_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (cause_reg != 3'd0));

    a_r9_priv_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> priv_mode);

    a_r9_priv_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(priv_mode) |-> $past(take));

    a_r10_priv_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(priv_mode) |-> $past(eret_req));

    a_r11_user_return_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!priv_mode && !take) |-> !redirect_valid);

endmodule

bind precise_exc_ctrl pexc_checker #(.NSTG(NSTG)) u_pexc_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .take           (take),
    .eret_req       (eret_req),
    .wb_commit      (wb_commit),
    .squash_younger (squash_younger),
    .redirect_valid (redirect_valid),
    .cause_reg      (cause_reg),
    .priv_mode      (priv_mode)
);

// File: tb/precise_exc_ctrl_test.sv
module precise_exc_ctrl_test;

    localparam int          PERIOD = 10;
    localparam int          XLEN   = 32;
    localparam int          NSTG   = 5;
    localparam logic [31:0] VBASE  = 32'h0000_0100;
    localparam logic [31:0] PC0    = 32'h0000_2000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fetch_valid = 1'b0;
    logic [XLEN-1:0]   fetch_pc = '0;
    logic [NSTG*3-1:0] raise_cause = '0;
    logic              eret_req = 1'b0;
    logic              eret_skip = 1'b0;
    logic              wb_commit;
    logic [NSTG-2:0]   squash_younger;
    logic              redirect_valid;
    logic [XLEN-1:0]   redirect_pc;
    logic [2:0]        cause_reg;
    logic [XLEN-1:0]   epc_reg;
    logic              priv_mode;

    int checks = 0;
    int errors = 0;
    logic [2:0] rz [0:15][0:4];

    always #(PERIOD/2) clk = ~clk;

    precise_exc_ctrl #(.XLEN(XLEN), .NSTG(NSTG), .VEC_BASE(VBASE)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .fetch_valid    (fetch_valid),
        .fetch_pc       (fetch_pc),
        .raise_cause    (raise_cause),
        .eret_req       (eret_req),
        .eret_skip      (eret_skip),
        .wb_commit      (wb_commit),
        .squash_younger (squash_younger),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .cause_reg      (cause_reg),
        .epc_reg        (epc_reg),
        .priv_mode      (priv_mode)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; fetch_valid = 1'b0; raise_cause = '0; eret_req = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 redirect", 32'(redirect_valid), 0);
        check("R1 squash", 32'(squash_younger), 0);
        check("R1 commit", 32'(wb_commit), 0);
        check("R1 priv", 32'(priv_mode), 0);
        check("R1 cause", 32'(cause_reg), 0);
        check("R1 epc", epc_reg, 0);
    endtask

    // fault on instruction idx at stage s1 (code c1), optional later stage s2 (c2),
    // optional younger instruction idx+1 raising at stage ys (code yc)
    task automatic run_case(input int idx, input int s1, input int c1, input int s2, input int c2,
                            input int ys, input int yc, input bit skip);
        int commits = 0;
        int early = 0;
        int leak = 0;
        int t_take = idx + 5;
        logic [31:0] epc_exp = PC0 + 32'(4 * idx);
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 5; b++) rz[a][b] = 3'd0;
        rz[idx][s1] = 3'(c1);
        if (s2 >= 0) rz[idx][s2] = 3'(c2);
        if (ys >= 0) rz[idx+1][ys] = 3'(yc);
        do_reset();
        for (int cyc = 0; cyc <= t_take; cyc++) begin
            @(negedge clk);
            fetch_valid = 1'b1;
            fetch_pc = PC0 + 32'(4 * cyc);
            for (int st = 0; st < 5; st++) begin
                int k = cyc - 1 - st;
                raise_cause[st*3 +: 3] = (k >= 0 && k < 16) ? rz[k][st] : 3'd0;
            end
            #1;
            if (cyc < t_take) begin
                if (redirect_valid) early++;
                if (wb_commit) commits++;
            end else begin
                check("R3 redirect at writeback", 32'(redirect_valid), 1);
                check("R5 vector", redirect_pc, VBASE + 32'(c1 * 16));
                check("R8 squash", 32'(squash_younger), 32'hF);
                check("R7 faulting no commit", 32'(wb_commit), 0);
            end
        end
        check("R3 no early redirect / R6 order", 32'(early), 0);
        check("R7 older commits", 32'(commits), 32'(idx));
        @(negedge clk);
        fetch_valid = 1'b0; raise_cause = '0;
        #1;
        check("R2 earliest cause kept", 32'(cause_reg), 32'(c1));
        check("R4 epc", epc_reg, epc_exp);
        check("R9 priv set", 32'(priv_mode), 1);
        for (int n = 0; n < 6; n++) begin
            if (wb_commit) leak++;
            @(negedge clk); #1;
        end
        check("R8 no squashed commit", 32'(leak), 0);
        eret_req = 1'b1; eret_skip = skip;
        #1;
        check("R10 return redirect", 32'(redirect_valid), 1);
        check("R10 return target", redirect_pc, skip ? epc_exp + 32'd4 : epc_exp);
        check("R10 return squash", 32'(squash_younger), 32'hF);
        @(negedge clk);
        eret_req = 1'b0;
        #1;
        check("R10 priv cleared", 32'(priv_mode), 0);
        @(negedge clk);
        eret_req = 1'b1; eret_skip = 1'b0;
        #1;
        check("R11 user return no redirect", 32'(redirect_valid), 0);
        check("R11 user return no squash", 32'(squash_younger), 0);
        @(negedge clk);
        eret_req = 1'b0;
        #1;
        check("R11 mode unchanged", 32'(priv_mode), 0);
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int idx = 0; idx < 3; idx++) begin
            for (int s1 = 0; s1 < 5; s1++) begin
                int c1 = 1 + ((idx + s1) % 7);
                run_case(idx, s1, c1, -1, 0, -1, 0, s1[0]);
                for (int s2 = s1 + 1; s2 < 5; s2++)
                    run_case(idx, s1, c1, s2, (c1 % 7) + 1, -1, 0, s2[0]);
            end
            for (int ys = 0; ys < 3; ys++)
                run_case(idx, 3, 2 + idx, -1, 0, ys, 7 - ys, ys[0]);
        end
        for (int c = 1; c < 8; c++)
            run_case(1, 1, c, -1, 0, -1, 0, c[0]);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule